// File: doc/BRIEF.md
# SPI Master with FIFO Level Interrupts

A register-mapped SPI master for a single slave. Software writes bytes into an eight-entry transmit queue. A shift engine takes each byte from the queue and sends it on MOSI, most significant bit first, in SPI mode 0. In the same frame it captures eight MISO bits, and the captured byte goes into an eight-entry receive queue. The serial clock rate is set by a divider field. A chip-select controller can pulse the select line for each frame, hold it low across a run of frames, or leave it undriven.

Two pending flags compare the queue occupancies with programmable marks. An enable register routes these flags onto a single interrupt line. The transmit flag depends only on how full the transmit queue is. It can therefore rise while the last popped byte is still on the wire. Software that must know when a frame has really ended waits for the matching received byte, even when it never uses the read data.

Top module: `spim_master`

## Requirements
- R1: After reset, sck_o is 0, cs_no is 1, irq_o is 0, the pending register reads 0, and the receive register reads with bit 31 set.
- R2: Each byte is shifted MSB first in mode 0. SCK idles low, MISO is sampled on the rising edge, and MOSI changes only while SCK is low.
- R3: The transmit data register is at offset 0x48, with data in bits [7:0]. A read of it returns the full flag in bit 31. A write while the queue holds 8 bytes is discarded.
- R4: Every frame pushes the byte captured from MISO into the receive queue. A read of offset 0x4C returns that byte in bits [7:0] and pops it. Bit 31 is set when the queue is empty. A byte that completes while the queue is full is discarded.
- R5: The divider is at offset 0x00, bits [11:0]. One SCK period lasts 2*(div+1) clock cycles.
- R6: Pending register bit 0 (offset 0x74) is 1 when the transmit queue count is less than the transmit mark (offset 0x50, bits [3:0]). It may become 1 while the last byte is still being shifted.
- R7: Pending register bit 1 is 1 when the receive queue count is greater than the receive mark (offset 0x54, bits [3:0]).
- R8: irq_o is the OR of the pending bits ANDed with the enable register at offset 0x70, which uses the same bit layout.
- R9: Chip-select mode is at offset 0x18, bits [1:0]. Values 0 and 1 (auto) hold cs_no low during every frame and return it high for at least one cycle between frames.
- R10: Mode 2 (hold) keeps cs_no low from the first frame onward for as long as the mode stays 2. Leaving the mode releases the line once no frame is running.
- R11: Mode 3 (off) keeps cs_oe_o at 0 and cs_no at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe, one access per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the cycle req_i is high |
| sck_o | output | 1 | Serial clock, idles low |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_no | output | 1 | Chip select, active low |
| cs_oe_o | output | 1 | Chip-select output enable |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions take for granted that every bus access lasts one cycle, and that the chip-select mode and divider stay constant while a frame is being shifted. The bench therefore changes these registers only after the frames it started have finished. It drives the bus on the falling clock edge and holds req_i for exactly one rising edge. The slave model changes MISO only after the rising SCK edge on which it was sampled, so the value the engine captures is always stable.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 8;
  localparam int BUS_W  = 32;

  localparam logic [ADDR_W-1:0] REG_CLK_DIV  = 8'h00;
  localparam logic [ADDR_W-1:0] REG_CS_MODE  = 8'h18;
  localparam logic [ADDR_W-1:0] REG_TX_PUSH  = 8'h48;
  localparam logic [ADDR_W-1:0] REG_RX_POP   = 8'h4C;
  localparam logic [ADDR_W-1:0] REG_TX_MARK  = 8'h50;
  localparam logic [ADDR_W-1:0] REG_RX_MARK  = 8'h54;
  localparam logic [ADDR_W-1:0] REG_IRQ_EN   = 8'h70;
  localparam logic [ADDR_W-1:0] REG_IRQ_PEND = 8'h74;

  localparam int IRQ_TX = 0;
  localparam int IRQ_RX = 1;
  localparam int FLAG_BIT = 31;

  typedef enum logic [1:0] {
    CS_AUTO     = 2'd0,
    CS_AUTO_ALT = 2'd1,
    CS_HOLD     = 2'd2,
    CS_OFF      = 2'd3
  } cs_mode_e;

  typedef enum logic {
    SH_IDLE = 1'b0,
    SH_RUN  = 1'b1
  } shift_state_e;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] data_o,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o,
  output logic             empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr, wr_nxt, rd_nxt;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  generate
    if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
    end else begin : g_wrap
      assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
    end
  endgenerate

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign data_o  = mem[rd_ptr];
  assign count_o = cnt_q;

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_ptr] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_nxt;
      if (do_pop)  rd_ptr <= rd_nxt;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter
  import spim_pkg::*;
#(
  parameter int DIV_W  = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              tx_valid_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              tx_pop_o,
  output logic              rx_push_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              busy_o,
  output logic              sck_o,
  output logic              mosi_o,
  input  logic              miso_i
);
  localparam int BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  shift_state_e      state_q;
  logic [DIV_W-1:0]  div_cnt_q;
  logic [BW-1:0]     bit_cnt_q;
  logic [DATA_W-1:0] tx_sh_q, rx_sh_q;
  logic              sck_q;
  logic              half_done, last_bit;

  assign half_done = (div_cnt_q == div_i);
  assign last_bit  = (bit_cnt_q == BW'(DATA_W - 1));
  assign tx_pop_o  = (state_q == SH_IDLE) && tx_valid_i;
  assign rx_push_o = (state_q == SH_RUN) && half_done && sck_q && last_bit;
  assign rx_data_o = rx_sh_q;
  assign busy_o    = (state_q == SH_RUN);
  assign sck_o     = sck_q;
  assign mosi_o    = tx_sh_q[DATA_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= SH_IDLE;
      div_cnt_q <= '0;
      bit_cnt_q <= '0;
      tx_sh_q   <= '0;
      rx_sh_q   <= '0;
      sck_q     <= 1'b0;
    end else begin
      case (state_q)
        SH_IDLE: begin
          if (tx_valid_i) begin
            tx_sh_q   <= tx_data_i;
            div_cnt_q <= '0;
            bit_cnt_q <= '0;
            sck_q     <= 1'b0;
            state_q   <= SH_RUN;
          end
        end
        SH_RUN: begin
          if (!half_done) begin
            div_cnt_q <= div_cnt_q + 1'b1;
          end else begin
            div_cnt_q <= '0;
            if (!sck_q) begin
              // rising edge: capture
              sck_q   <= 1'b1;
              rx_sh_q <= {rx_sh_q[DATA_W-2:0], miso_i};
            end else begin
              // falling edge: advance
              sck_q <= 1'b0;
              if (last_bit) begin
                state_q <= SH_IDLE;
              end else begin
                bit_cnt_q <= bit_cnt_q + 1'b1;
                tx_sh_q   <= {tx_sh_q[DATA_W-2:0], 1'b0};
              end
            end
          end
        end
        default: state_q <= SH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spim_cs_ctrl.sv
module spim_cs_ctrl
  import spim_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  cs_mode_e mode_i,
  input  logic     frame_start_i,
  input  logic     busy_i,
  output logic     cs_no,
  output logic     cs_oe_o
);
  logic hold_q;
  logic active;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 hold_q <= 1'b0;
    else if (mode_i != CS_HOLD)  hold_q <= 1'b0;
    else if (frame_start_i)      hold_q <= 1'b1;
  end

  always_comb begin
    case (mode_i)
      CS_HOLD: active = hold_q || busy_i;
      CS_OFF:  active = 1'b0;
      default: active = busy_i;
    endcase
  end

  assign cs_no   = !active;
  assign cs_oe_o = (mode_i != CS_OFF);
endmodule

// File: rtl/spim_master.sv
module spim_master
  import spim_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int DIV_W      = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  output logic              sck_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic              cs_no,
  output logic              cs_oe_o,
  output logic              irq_o
);
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  logic [DIV_W-1:0]  div_q;
  cs_mode_e          cs_mode_q;
  logic [CNT_W-1:0]  tx_mark_q, rx_mark_q;
  logic [1:0]        irq_en_q;
  logic [1:0]        irq_pend;

  logic              tx_push, tx_pop, tx_full, tx_empty;
  logic [BYTE_W-1:0] tx_head;
  logic [CNT_W-1:0]  tx_cnt;
  logic              rx_push, rx_pop, rx_full, rx_empty;
  logic [BYTE_W-1:0] rx_head, rx_byte;
  logic [CNT_W-1:0]  rx_cnt;
  logic              shift_busy;

  assign tx_push = req_i && we_i && (addr_i == REG_TX_PUSH);
  assign rx_pop  = req_i && !we_i && (addr_i == REG_RX_POP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q     <= '0;
      cs_mode_q <= CS_AUTO;
      tx_mark_q <= '0;
      rx_mark_q <= '0;
      irq_en_q  <= '0;
    end else if (req_i && we_i) begin
      case (addr_i)
        REG_CLK_DIV: div_q     <= wdata_i[DIV_W-1:0];
        REG_CS_MODE: cs_mode_q <= cs_mode_e'(wdata_i[1:0]);
        REG_TX_MARK: tx_mark_q <= wdata_i[CNT_W-1:0];
        REG_RX_MARK: rx_mark_q <= wdata_i[CNT_W-1:0];
        REG_IRQ_EN:  irq_en_q  <= wdata_i[1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    irq_pend         = '0;
    irq_pend[IRQ_TX] = (tx_cnt < tx_mark_q);
    irq_pend[IRQ_RX] = (rx_cnt > rx_mark_q);
  end
  assign irq_o = |(irq_pend & irq_en_q);

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      REG_CLK_DIV:  rdata_o[DIV_W-1:0] = div_q;
      REG_CS_MODE:  rdata_o[1:0] = cs_mode_q;
      REG_TX_PUSH:  rdata_o[FLAG_BIT] = tx_full;
      REG_RX_POP: begin
        rdata_o[FLAG_BIT]     = rx_empty;
        rdata_o[BYTE_W-1:0]   = rx_empty ? '0 : rx_head;
      end
      REG_TX_MARK:  rdata_o[CNT_W-1:0] = tx_mark_q;
      REG_RX_MARK:  rdata_o[CNT_W-1:0] = rx_mark_q;
      REG_IRQ_EN:   rdata_o[1:0] = irq_en_q;
      REG_IRQ_PEND: rdata_o[1:0] = irq_pend;
      default: ;
    endcase
  end

  spim_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(BYTE_W), .CNT_W(CNT_W)) u_tx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (tx_push),
    .data_i  (wdata_i[BYTE_W-1:0]),
    .pop_i   (tx_pop),
    .data_o  (tx_head),
    .count_o (tx_cnt),
    .full_o  (tx_full),
    .empty_o (tx_empty)
  );

  spim_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(BYTE_W), .CNT_W(CNT_W)) u_rx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (rx_push),
    .data_i  (rx_byte),
    .pop_i   (rx_pop),
    .data_o  (rx_head),
    .count_o (rx_cnt),
    .full_o  (rx_full),
    .empty_o (rx_empty)
  );

  spim_shifter #(.DIV_W(DIV_W), .DATA_W(BYTE_W)) u_shifter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .div_i      (div_q),
    .tx_valid_i (!tx_empty),
    .tx_data_i  (tx_head),
    .tx_pop_o   (tx_pop),
    .rx_push_o  (rx_push),
    .rx_data_o  (rx_byte),
    .busy_o     (shift_busy),
    .sck_o      (sck_o),
    .mosi_o     (mosi_o),
    .miso_i     (miso_i)
  );

  spim_cs_ctrl u_cs_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .mode_i        (cs_mode_q),
    .frame_start_i (tx_pop),
    .busy_i        (shift_busy),
    .cs_no         (cs_no),
    .cs_oe_o       (cs_oe_o)
  );
endmodule

// File: rtl/spim_master_checker.sv
module spim_master_checker #(
  parameter int FIFO_DEPTH = 8,
  parameter int CNT_W      = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sck_o,
  input logic             mosi_o,
  input logic             cs_no,
  input logic             cs_oe_o,
  input logic             irq_o,
  input logic             shift_busy,
  input logic [1:0]       cs_mode,
  input logic [1:0]       irq_en,
  input logic [CNT_W-1:0] tx_cnt,
  input logic             tx_full,
  input logic             tx_push
);
  assert_sck_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_busy |-> !sck_o);

  assert_mosi_steady_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_o && $past(sck_o)) |-> $stable(mosi_o));

  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_cnt <= CNT_W'(FIFO_DEPTH));

  assert_full_drop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_push && tx_full) |=> (tx_cnt <= $past(tx_cnt)));

  assert_irq_masked_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_en == 2'b00) |-> !irq_o);

  assert_cs_in_frame_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cs_mode != 2'd3) && $rose(sck_o)) |-> !cs_no);

  assert_cs_off_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_mode == 2'd3) |-> (!cs_oe_o && cs_no));
endmodule

bind spim_master spim_master_checker #(.FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sck_o      (sck_o),
  .mosi_o     (mosi_o),
  .cs_no      (cs_no),
  .cs_oe_o    (cs_oe_o),
  .irq_o      (irq_o),
  .shift_busy (shift_busy),
  .cs_mode    (cs_mode_q),
  .irq_en     (irq_en_q),
  .tx_cnt     (tx_cnt),
  .tx_full    (tx_full),
  .tx_push    (tx_push)
);

// File: tb/spim_master_bench.sv
module spim_master_bench;
  import spim_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        sck, mosi, miso, cs_n, cs_oe, irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  spim_master u_spim_master (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .sck_o(sck), .mosi_o(mosi),
    .miso_i(miso), .cs_no(cs_n), .cs_oe_o(cs_oe), .irq_o(irq)
  );

  int n_tests = 0, n_fail = 0;
  logic [7:0] exp_tx_q[$];
  logic [7:0] exp_rx_q[$];
  int bit_cnt = 0, frame_idx = 0, cs_viol = 0, cs_rises = 0, cs_falls = 0, sck_period = 0;
  longint last_rise = 0;
  logic [7:0] mosi_sh = '0, cur_reply;
  logic [1:0] cs_mode_cur = 2'd0;

  function automatic logic [7:0] reply_of(int n);
    return 8'(n * 37 + 90);
  endfunction

  task automatic check(bit ok, string req_tag, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h", req_tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  // slave model: MISO from reply sequence, MOSI scoreboard monitor
  always_comb begin
    cur_reply = reply_of(frame_idx);
    miso = cur_reply[3'(7 - bit_cnt)];
  end

  always @(posedge sck) begin
    if (cs_mode_cur != 2'd3 && cs_n) cs_viol++;
    if (bit_cnt != 0) sck_period = int'($time - last_rise) / CLK_PERIOD;
    last_rise = $time;
    mosi_sh = {mosi_sh[6:0], mosi};
    if (bit_cnt == 7) begin
      bit_cnt = 0;
      exp_rx_q.push_back(reply_of(frame_idx));
      frame_idx++;
      if (exp_tx_q.size() == 0) check(1'b0, "R2", "unexpected frame", {24'h0, mosi_sh}, 32'h0);
      else begin
        logic [7:0] e;
        e = exp_tx_q.pop_front();
        check(mosi_sh == e, "R2", "mosi byte", {24'h0, mosi_sh}, {24'h0, e});
      end
    end else bit_cnt++;
  end

  always @(posedge cs_n) cs_rises++;
  always @(negedge cs_n) cs_falls++;

  task automatic bus_write(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    if (a == REG_CS_MODE) cs_mode_cur = d[1:0];
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_read(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic push_tx(logic [7:0] b, bit accepted);
    bus_write(REG_TX_PUSH, {24'h0, b});
    if (accepted) exp_tx_q.push_back(b);
  endtask

  task automatic wait_frames(int target);
    int guard = 0;
    while (frame_idx < target && guard < 20000) begin
      @(posedge clk);
      guard++;
    end
    repeat (40) @(posedge clk);
  endtask

  task automatic drain_rx(int n);
    logic [31:0] d;
    for (int i = 0; i < n; i++) begin
      logic [7:0] e;
      bus_read(REG_RX_POP, d);
      e = (exp_rx_q.size() != 0) ? exp_rx_q.pop_front() : 8'hxx;
      check(!d[31] && d[7:0] == e, "R4", "rx byte", d, {24'h0, e});
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired act=%0d exp=%0d", frame_idx, -1);
    finish_run();
  end

  initial begin
    logic [31:0] d;
    int base, rises0, falls0, seen;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(sck == 1'b0, "R1", "sck idle", {31'h0, sck}, 32'h0);
    check(cs_n == 1'b1 && cs_oe == 1'b1, "R1", "cs idle", {30'h0, cs_oe, cs_n}, 32'h3);
    check(irq == 1'b0, "R1", "irq", {31'h0, irq}, 32'h0);
    bus_read(REG_IRQ_PEND, d);
    check(d == 32'h0, "R1", "pending", d, 32'h0);
    bus_read(REG_RX_POP, d);
    check(d[31] == 1'b1, "R1", "rx empty flag", d, 32'h8000_0000);

    // R9 auto mode, R5 fastest divider
    rises0 = cs_rises;
    push_tx(8'hA1, 1); push_tx(8'hB2, 1); push_tx(8'h3C, 1);
    wait_frames(3);
    check(sck_period == 2, "R5", "sck period div=0", sck_period, 2);
    check(cs_rises - rises0 == 3, "R9", "cs release per frame", cs_rises - rises0, 3);
    drain_rx(3);

    // R5 slower divider
    bus_write(REG_CLK_DIV, 32'd3);
    push_tx(8'h81, 1); push_tx(8'h7E, 1);
    wait_frames(5);
    check(sck_period == 8, "R5", "sck period div=3", sck_period, 8);
    drain_rx(2);

    // R6/R7/R8 watermarks
    bus_write(REG_TX_MARK, 32'd1);
    bus_write(REG_RX_MARK, 32'd1);
    base = frame_idx;
    push_tx(8'h55, 1); push_tx(8'hF0, 1);
    bus_read(REG_IRQ_PEND, d);
    check(d[0] == 1'b0, "R6", "tx pending clear with one queued", d, 32'h0);
    seen = 0;
    for (int i = 0; i < 500 && !seen; i++) begin
      bus_read(REG_IRQ_PEND, d);
      if (d[0]) seen = 1;
    end
    check(seen == 1 && frame_idx - base == 1, "R6", "tx pending while last byte shifts",
          frame_idx - base, 1);
    check(d[1] == 1'b0, "R7", "rx pending with one byte", d, 32'h1);
    wait_frames(base + 2);
    bus_read(REG_IRQ_PEND, d);
    check(d[1:0] == 2'b11, "R7", "rx pending with two bytes", d, 32'h3);
    check(irq == 1'b0, "R8", "irq masked", {31'h0, irq}, 32'h0);
    bus_write(REG_IRQ_EN, 32'h2);
    @(negedge clk);
    check(irq == 1'b1, "R8", "irq via rx enable", {31'h0, irq}, 32'h1);
    drain_rx(1);
    @(negedge clk);
    check(irq == 1'b0, "R8", "irq drops with rx at mark", {31'h0, irq}, 32'h0);
    bus_write(REG_IRQ_EN, 32'h1);
    @(negedge clk);
    check(irq == 1'b1, "R8", "irq via tx enable", {31'h0, irq}, 32'h1);
    drain_rx(1);
    bus_read(REG_IRQ_PEND, d);
    check(d[1:0] == 2'b01, "R7", "rx pending clear after drain", d, 32'h1);
    bus_write(REG_IRQ_EN, 32'h0);
    bus_write(REG_TX_MARK, 32'd0);
    bus_write(REG_RX_MARK, 32'd0);

    // R10 hold mode
    bus_write(REG_CS_MODE, 32'd2);
    rises0 = cs_rises;
    push_tx(8'h11, 1); push_tx(8'h22, 1); push_tx(8'h33, 1);
    wait_frames(frame_idx + 3);
    check(cs_rises == rises0 && cs_n == 1'b0, "R10", "cs held across frames",
          cs_rises - rises0, 0);
    bus_write(REG_CS_MODE, 32'd0);
    @(negedge clk);
    check(cs_n == 1'b1 && cs_rises - rises0 == 1, "R10", "cs released on mode exit",
          {31'h0, cs_n}, 32'h1);
    drain_rx(3);

    // R11 off mode
    bus_write(REG_CS_MODE, 32'd3);
    falls0 = cs_falls;
    check(cs_oe == 1'b0 && cs_n == 1'b1, "R11", "cs undriven", {30'h0, cs_oe, cs_n}, 32'h1);
    push_tx(8'hC7, 1); push_tx(8'h18, 1);
    wait_frames(frame_idx + 2);
    check(cs_falls == falls0 && cs_oe == 1'b0, "R11", "no cs activity", cs_falls - falls0, 0);
    drain_rx(2);

    // R9 reserved mode acts as auto
    bus_write(REG_CS_MODE, 32'd1);
    rises0 = cs_rises;
    push_tx(8'h96, 1); push_tx(8'h69, 1);
    wait_frames(frame_idx + 2);
    check(cs_rises - rises0 == 2, "R9", "mode 1 releases per frame", cs_rises - rises0, 2);
    drain_rx(2);
    bus_write(REG_CS_MODE, 32'd0);

    // R3 full queue drop, R4 rx overflow drop
    bus_write(REG_CLK_DIV, 32'd2);
    base = frame_idx;
    for (int i = 0; i < 9; i++) push_tx(8'(8'h40 + i), 1);
    bus_read(REG_TX_PUSH, d);
    check(d[31] == 1'b1, "R3", "full flag", d, 32'h8000_0000);
    push_tx(8'hEE, 0);
    wait_frames(base + 9);
    repeat (100) @(posedge clk);
    check(frame_idx - base == 9 && exp_tx_q.size() == 0, "R3", "dropped write not sent",
          frame_idx - base, 9);
    bus_read(REG_TX_PUSH, d);
    check(d[31] == 1'b0, "R3", "full flag clear", d, 32'h0);
    drain_rx(8);
    void'(exp_rx_q.pop_back());
    bus_read(REG_RX_POP, d);
    check(d[31] == 1'b1, "R4", "ninth byte dropped on full rx", d, 32'h8000_0000);

    check(cs_viol == 0, "R9", "cs low at every sck rise", cs_viol, 0);
    finish_run();
  end
endmodule